// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block is the power-management corner of a small microcontroller. It holds an 8-bit power control register, mapped at direct address 0x87, and turns its two mode bits into gating signals. When the idle bit is set, the CPU clock stops but the interrupt, timer and serial-port logic keep running. When the power-down bit is set, the oscillator is stopped and everything freezes. The CPU core, interrupt controller, timers, serial port and oscillator lie outside the block. They reach it through a write port, an "enabled interrupt pending" flag and the oscillator clock.

Idle ends in one of two ways. An enabled interrupt clears the idle bit in hardware. The reset pin clears the bit asynchronously. The CPU clock comes back at once in both cases. Leaving idle through the reset pin also opens a short window, of three machine cycles of twelve oscillator periods each, in which internal-RAM access is blocked. Port access stays open during that window. This covers the few instructions the CPU may run before the internal reset sequence takes over. A separate cold (power-on) reset clears the memory that ties the window to an idle exit.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the reset pin is low, the register reads 0x00. The CPU clock, peripheral clock and oscillator enables read 1, and the RAM-inhibit output reads 0.
- R2: A write strobe with address 0x87 loads data bit 7 (double baud rate), bit 3 (flag 1), bit 2 (flag 0), bit 1 (power-down) and bit 0 (idle). Bits 6..4 always read 0. A write to any other address leaves the register unchanged.
- R3: With the idle bit (bit 0) set, the CPU clock enable is 0. The peripheral clock and oscillator enables stay 1, and the strobe hold-high and port-hold outputs are 1.
- R4: With the power-down bit (bit 1) set, the CPU clock, peripheral clock and oscillator enables are 0, port-hold is 1 and strobe hold-high is 0.
- R5: A write with both bit 1 and bit 0 set stores power-down = 1 and idle = 0.
- R6: An interrupt pending flag seen at a clock edge while idle clears the idle bit at that edge. The flag has no effect on the register outside idle and power-down.
- R7: While idle or power-down is set, register writes are ignored. While power-down is set, the interrupt flag has no effect.
- R8: The flag bits read back as written and do not change any enable or hold output.
- R9: A low reset pin clears the idle and power-down bits with no clock edge needed. The register stays in reset until the second clock edge after the pin rises, so a write in the cycle ending at that edge is ignored.
- R10: A reset that ends an idle period raises RAM-inhibit from the first clock edge that sees reset, for exactly 36 clock cycles (3 machine cycles of 12 periods). A reset taken outside idle, including one after an interrupt wake, leaves RAM-inhibit at 0. A cold reset clears RAM-inhibit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Cold power-on reset, active low |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Direct address of the write |
| wr_data | input | 8 | Write data |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| pctl_q | output | 8 | Current power control register value |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| osc_en | output | 1 | Oscillator run enable |
| strobe_hold | output | 1 | Drive external bus strobes high |
| port_hold | output | 1 | Freeze port output values |
| ram_inh | output | 1 | Block internal-RAM access |

## Verification
The hardest case to reach is the RAM-inhibit window. It needs idle to be active at the moment the reset pin falls, and after that the register has already been wiped. The bench first writes the idle bit and then drops the reset pin halfway through a clock low phase. It checks the asynchronous clear before any edge, then counts the inhibit cycles across the pin's release. Control runs repeat the reset after a non-idle state and after an interrupt wake, and a cold reset is applied in the middle of a window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int BIT_IDLE  = 0;
  localparam int BIT_PDOWN = 1;
  localparam int BIT_FLAG0 = 2;
  localparam int BIT_FLAG1 = 3;
  localparam int BIT_DBAUD = 7;

  typedef struct packed {
    logic       dbl_baud;
    logic [2:0] rsv;
    logic       flag1;
    logic       flag0;
    logic       pdown;
    logic       idle;
  } pctl_t;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       irq_pend,
  output pctl_t      ctl_q
);
  pctl_t ctl_nxt;
  logic  wr_hit, held, wake, ld_en;

  always_comb begin
    wr_hit  = wr_en && (wr_addr == CTRL_ADDR);
    held    = ctl_q.idle || ctl_q.pdown;
    wake    = ctl_q.idle && irq_pend;
    ld_en   = wake || (!held && wr_hit);
    ctl_nxt = ctl_q;
    if (held) begin
      if (wake) ctl_nxt.idle = 1'b0;
    end else if (wr_hit) begin
      ctl_nxt.dbl_baud = wr_data[BIT_DBAUD];
      ctl_nxt.flag1    = wr_data[BIT_FLAG1];
      ctl_nxt.flag0    = wr_data[BIT_FLAG0];
      ctl_nxt.pdown    = wr_data[BIT_PDOWN];
      ctl_nxt.idle     = wr_data[BIT_IDLE] && !wr_data[BIT_PDOWN];
    end
    ctl_nxt.rsv = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (ld_en) ctl_q <= ctl_nxt;
  end

  AST_PDOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !held && wr_data[BIT_PDOWN] && wr_data[BIT_IDLE]) |=> (ctl_q.pdown && !ctl_q.idle)); // R5
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.idle && irq_pend) |=> !ctl_q.idle); // R6
  AST_WR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !irq_pend) |=> $stable(ctl_q)); // R7
endmodule

// File: rtl/pmc_inhibit_win.sv
module pmc_inhibit_win #(
  parameter int WIN_CYC = 36
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_sync_n,
  input  logic idle,
  output logic ram_inh
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          was_idle_q, was_idle_nxt;
  logic          launch;

  always_comb begin
    launch       = !rst_sync_n && was_idle_q && (cnt_q == '0);
    cnt_nxt      = cnt_q;
    was_idle_nxt = was_idle_q;
    if (launch)              cnt_nxt = WIN_L;
    else if (cnt_q != '0)    cnt_nxt = cnt_q - 1'b1;
    if (!rst_sync_n) begin
      if (launch) was_idle_nxt = 1'b0;
    end else begin
      was_idle_nxt = idle;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q      <= '0;
      was_idle_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      was_idle_q <= was_idle_nxt;
    end
  end

  assign ram_inh = (cnt_q != '0);

  AST_INH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ram_inh) |-> $past(was_idle_q)); // R10
  AST_INH_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ram_inh) |-> $past(!rst_sync_n)); // R10
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR   = 8'h87,
  parameter int         OSC_PER_MC  = 12,
  parameter int         INH_MC      = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       irq_pend,
  output logic [7:0] pctl_q,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       strobe_hold,
  output logic       port_hold,
  output logic       ram_inh
);
  localparam int WIN_CYC = OSC_PER_MC * INH_MC;

  logic  arst_n, rst_sync_n;
  pctl_t ctl;

  assign arst_n = rst_n && por_n;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  pmc_ctrl_reg #(.CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_pend (irq_pend),
    .ctl_q    (ctl)
  );

  pmc_inhibit_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk        (clk),
    .por_n      (por_n),
    .rst_sync_n (rst_sync_n),
    .idle       (ctl.idle),
    .ram_inh    (ram_inh)
  );

  assign pctl_q      = ctl;
  assign cpu_clk_en  = !(ctl.idle || ctl.pdown);
  assign per_clk_en  = !ctl.pdown;
  assign osc_en      = !ctl.pdown;
  assign strobe_hold = ctl.idle;
  assign port_hold   = ctl.idle || ctl.pdown;

  AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == CTRL_ADDR && !port_hold && wr_data[0] && !wr_data[1])
    |=> (!cpu_clk_en && per_clk_en && osc_en && strobe_hold)); // R3
  AST_PDOWN_STOPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == CTRL_ADDR && !port_hold && wr_data[1])
    |=> (!osc_en && !per_clk_en && !cpu_clk_en && !strobe_hold)); // R4
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       por_n, rst_n, wr_en, irq_pend;
  logic [7:0] wr_addr, wr_data;
  logic [7:0] pctl_q;
  logic       cpu_clk_en, per_clk_en, osc_en, strobe_hold, port_hold, ram_inh;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_pend(irq_pend), .pctl_q(pctl_q), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .strobe_hold(strobe_hold),
    .port_hold(port_hold), .ram_inh(ram_inh)
  );

  // {wr, addr, data, irq, expected register, expected {cpu,per,osc,strobe,port}}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 8'h87, 8'h8C, 1'b0, 8'h8C, 5'b11100},
    {1'b1, 8'h87, 8'h70, 1'b0, 8'h00, 5'b11100},
    {1'b1, 8'h86, 8'hFF, 1'b0, 8'h00, 5'b11100},
    {1'b1, 8'h87, 8'h0D, 1'b0, 8'h0D, 5'b01111},
    {1'b1, 8'h87, 8'h00, 1'b0, 8'h0D, 5'b01111},
    {1'b0, 8'h00, 8'h00, 1'b1, 8'h0C, 5'b11100},
    {1'b0, 8'h00, 8'h00, 1'b1, 8'h0C, 5'b11100},
    {1'b1, 8'h87, 8'h08, 1'b0, 8'h08, 5'b11100},
    {1'b1, 8'h87, 8'h03, 1'b0, 8'h02, 5'b00001},
    {1'b1, 8'h87, 8'h00, 1'b1, 8'h02, 5'b00001}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R3";
      4, 9:    return "R7";
      5, 6:    return "R6";
      7:       return "R8";
      default: return "R5 R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, strobe_hold, port_hold};
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d, logic irq);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; irq_pend = irq;
    @(negedge clk);
    wr_en = 1'b0; irq_pend = 1'b0;
  endtask

  task automatic release_rst();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // drop the pin mid low phase, count inhibit cycles over a span
  task automatic rst_count(int hold, int span, output int ones, output logic first);
    ones = 0; first = 1'b0;
    @(negedge clk); #2 rst_n = 1'b0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (ram_inh) ones++;
      if (i == 0) first = ram_inh;
      if (i == hold) rst_n = 1'b1;
    end
  endtask

  initial begin
    int   ones;
    logic first;
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reg", pctl_q, 8'h00);
    chk("R1 enables", {cpu_clk_en, per_clk_en, osc_en, ram_inh}, 4'b1110);
    por_n = 1'b1;
    release_rst();

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wr(v[29:22], v[21:14], v[13]);
      chk(vtag(i), pctl_q, v[12:5]);
      chk(vtag(i), outs(), v[4:0]);
      if (!v[30] && i == 6) chk("R6 no-op", pctl_q, 8'h0C);
    end

    // R9: reset from power-down restarts the oscillator, no inhibit
    rst_count(30, 45, ones, first);
    chk("R9 pd cleared", {pctl_q, osc_en}, {8'h00, 1'b1});
    chk("R10 no window from pd", ones, 0);

    // R9: asynchronous clear of idle, then R10 window
    wr(8'h87, 8'h01, 1'b0);
    chk("R3 idle set", pctl_q, 8'h01);
    @(negedge clk); #2 rst_n = 1'b0; #1;
    chk("R9 async clear", {pctl_q, cpu_clk_en}, {8'h00, 1'b1});
    ones = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ram_inh) ones++;
      if (i == 0) chk("R10 first edge", ram_inh, 1'b1);
      if (i == 30) rst_n = 1'b1;
    end
    chk("R10 window length", ones, 36);

    // R9: write in cycle ending at second edge after release is ignored
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(8'h87, 8'h04, 1'b0);
    chk("R9 sync release", pctl_q, 8'h00);
    wr(8'h87, 8'h04, 1'b0);
    chk("R8 flag write", {pctl_q, outs()}, {8'h04, 5'b11100});

    // R10: reset outside idle
    rst_count(30, 45, ones, first);
    chk("R10 no window non-idle", ones, 0);
    release_rst();

    // R10: interrupt wake then reset gives no window
    wr(8'h87, 8'h01, 1'b0);
    wr(8'h00, 8'h00, 1'b1);
    chk("R6 wake", {pctl_q, cpu_clk_en}, {8'h00, 1'b1});
    rst_count(30, 45, ones, first);
    chk("R10 no window after wake", ones, 0);
    release_rst();

    // R10: cold reset cuts a running window
    wr(8'h87, 8'h01, 1'b0);
    @(negedge clk); #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 window open", ram_inh, 1'b1);
    #1 por_n = 1'b0; #1;
    chk("R10 cold clear", ram_inh, 1'b0);
    @(negedge clk); por_n = 1'b1;
    release_rst();
    chk("R1 after cold", {pctl_q, ram_inh}, 9'h000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule